// File: doc/BRIEF.md
# Secondary Clock Output Gating Controller

This block produces a bank of secondary clock outputs that copy a reference clock, and can turn off each output on its own. A turned-off output parks at a static high level. A separate power-down condition parks every output low. All logic runs on one fast sampling clock `clk`. The reference clock is sampled on it, and each output is a register, so the outputs are phase-locked to the sampled reference with a fixed latency.

A 10-bit disable register decides which outputs are parked high. It can be loaded in two ways. During a reset window, bits arrive on a serial pin with its own shift strobe. Once that window closes, software can write the register through a small write/read port. A strap pin enables the power-down behaviour. When the strap is set and the power-state code asks for a deep state, every output is pulled low, whatever the register holds. A change of mode on any output is held back until it cannot cut a clock phase short.

Top module: `sclk_gate_ctrl`

## Requirements
- R1: While `p_rst` is high (synchronous, active high), `cfg_rdata` reads 0 and every bit of `sclk_o` is 0.
- R2: An enabled output that is not forced low equals `ref_clk` as sampled two `clk` rising edges earlier. `ref_clk` is registered once, and the output is registered once more.
- R3: The serial window opens in the first cycle after `p_rst` falls, if `s_rst` is high at that point. In the window, each rising edge of `msk_sck` shifts `msk_din` into bit 0 of the disable register and moves the older bits up by one. Both pins pass through a two-stage synchronizer first. After ten bits, the first bit received sits in bit 9.
- R4: The window closes after the tenth bit. Later `msk_sck` edges leave the register unchanged.
- R5: The window closes early as soon as `s_rst` goes low. Bits already received stay in the low-order bits, and later edges are ignored.
- R6: A serial stream of all zeros leaves every output passing the clock. A stream of all ones parks every output at 1.
- R7: A disable register bit of 1 parks the matching output at 1. A write (`cfg_we` high for one cycle) loads `cfg_wdata` into the register once the window has closed. `cfg_rdata` always shows the register.
- R8: Writes attempted before or during the serial window are ignored.
- R9: With `pm_strap` high and `pwr_state` equal to 2 or 3, every output goes to 0. This overrides the disable register.
- R10: With `pm_strap` low, or with `pwr_state` equal to 0 or 1, the power state has no effect on the outputs.
- R11: An output changes level only in the cycle after the sampled reference changed. A mode switch therefore never makes a shortened high or low phase, and a move between parked-high and parked-low passes through one pass-through phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| p_rst | input | 1 | Primary reset, synchronous, active high |
| s_rst | input | 1 | Secondary reset level, active high; defines the serial window |
| ref_clk | input | 1 | Reference clock to be copied onto the outputs |
| msk_sck | input | 1 | Serial mask shift strobe; bits are taken on its rising edge |
| msk_din | input | 1 | Serial mask data, 1 = park output high |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 10 | Register write data, bit i controls output i |
| cfg_rdata | output | 10 | Current disable register contents |
| pwr_state | input | 2 | Power-state code: 0 and 1 running, 2 and 3 deep |
| pm_strap | input | 1 | Strap that lets deep power states stop the outputs |
| sclk_o | output | 10 | Secondary clock outputs |

## Verification
The lane checks assume that the reference holds each level for at least two `clk` cycles. That way a mode step through pass-through always finds a matching phase, and the output register sees every reference level. The bench drives a free-running reference with four-cycle half periods. It keeps `msk_sck` low while reset is held and holds each strobe level for four cycles, well above the two synchronizer stages. Power-state and register changes are applied at arbitrary times, and the bench then waits more than a full reference period before comparing pass-through and parked levels.

// File: rtl/sclk_gate_pkg.sv
package sclk_gate_pkg;

  typedef enum logic [1:0] {
    MD_PASS = 2'd0,
    MD_HIGH = 2'd1,
    MD_LOW  = 2'd2
  } clk_mode_e;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_RUN  = 2'd1,
    CAP_DONE = 2'd2
  } cap_state_e;

  // output level a mode yields for a given sampled reference level
  function automatic logic mode_level(input clk_mode_e m, input logic r);
    case (m)
      MD_PASS: return r;
      MD_HIGH: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sclk_mask_capture.sv
module sclk_mask_capture
  import sclk_gate_pkg::*;
#(
  parameter int N_OUT       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_rst,
  input  logic             msk_sck,
  input  logic             msk_din,
  input  logic             wr_en,
  input  logic [N_OUT-1:0] wr_data,
  output logic [N_OUT-1:0] dis_q
);

  localparam int CW = $clog2(N_OUT + 1);

  logic [SYNC_STAGES-1:0] sck_sync;
  logic [SYNC_STAGES-1:0] din_sync;
  logic                   sck_prev;
  logic                   shift;
  cap_state_e             state_q;
  logic [CW-1:0]          cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sync <= '0;
      din_sync <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], msk_sck};
      din_sync <= {din_sync[SYNC_STAGES-2:0], msk_din};
      sck_prev <= sck_sync[SYNC_STAGES-1];
    end
  end

  assign shift = sck_sync[SYNC_STAGES-1] & ~sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CAP_IDLE;
      cnt_q   <= '0;
      dis_q   <= '0;
    end else begin
      case (state_q)
        CAP_IDLE: state_q <= s_rst ? CAP_RUN : CAP_DONE;
        CAP_RUN: begin
          if (!s_rst) begin
            state_q <= CAP_DONE;
          end else if (shift) begin
            dis_q <= {dis_q[N_OUT-2:0], din_sync[SYNC_STAGES-1]};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(N_OUT - 1)) state_q <= CAP_DONE;
          end
        end
        default: begin
          if (wr_en) dis_q <= wr_data;
        end
      endcase
    end
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(N_OUT));

  // R8
  no_write_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == CAP_RUN && !shift) |=> $stable(dis_q));

  // R5
  window_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == CAP_DONE) |=> (state_q == CAP_DONE));

endmodule

// File: rtl/sclk_lane.sv
module sclk_lane
  import sclk_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ref_s,
  input  clk_mode_e tgt,
  output logic      clk_o
);

  clk_mode_e mode_q;
  clk_mode_e mode_n;
  logic      ref_p;

  // switch only when the new mode gives the same level right now;
  // otherwise step through pass-through when that matches
  always_comb begin
    mode_n = mode_q;
    if (mode_level(tgt, ref_s) == mode_level(mode_q, ref_s))
      mode_n = tgt;
    else if (mode_level(MD_PASS, ref_s) == mode_level(mode_q, ref_s))
      mode_n = MD_PASS;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MD_LOW;
      clk_o  <= 1'b0;
      ref_p  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      clk_o  <= mode_level(mode_n, ref_s);
      ref_p  <= ref_s;
    end
  end

  // R11
  no_runt_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_s == ref_p) |=> $stable(clk_o));

  // R9
  low_parked_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_LOW) |-> !clk_o);

  // R7
  high_parked_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_HIGH) |-> clk_o);

endmodule

// File: rtl/sclk_gate_ctrl.sv
module sclk_gate_ctrl
  import sclk_gate_pkg::*;
#(
  parameter int N_OUT       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             p_rst,
  input  logic             s_rst,
  input  logic             ref_clk,
  input  logic             msk_sck,
  input  logic             msk_din,
  input  logic             cfg_we,
  input  logic [N_OUT-1:0] cfg_wdata,
  output logic [N_OUT-1:0] cfg_rdata,
  input  logic [1:0]       pwr_state,
  input  logic             pm_strap,
  output logic [N_OUT-1:0] sclk_o
);

  logic             ref_s;
  logic             force_low;
  logic [N_OUT-1:0] dis;

  always_ff @(posedge clk) begin
    if (p_rst) ref_s <= 1'b0;
    else       ref_s <= ref_clk;
  end

  // codes 2 and 3 are the deep states
  assign force_low = pm_strap & pwr_state[1];

  sclk_mask_capture #(
    .N_OUT      (N_OUT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_cap (
    .clk    (clk),
    .rst    (p_rst),
    .s_rst  (s_rst),
    .msk_sck(msk_sck),
    .msk_din(msk_din),
    .wr_en  (cfg_we),
    .wr_data(cfg_wdata),
    .dis_q  (dis)
  );

  assign cfg_rdata = dis;

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    clk_mode_e tgt;
    always_comb begin
      if (force_low)   tgt = MD_LOW;
      else if (dis[i]) tgt = MD_HIGH;
      else             tgt = MD_PASS;
    end

    sclk_lane u_lane (
      .clk  (clk),
      .rst  (p_rst),
      .ref_s(ref_s),
      .tgt  (tgt),
      .clk_o(sclk_o[i])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(p_rst) |-> (sclk_o == '0 && cfg_rdata == '0));

endmodule

// File: tb/tb_sclk_gate_ctrl.sv
`timescale 1ns/1ps
module tb_sclk_gate_ctrl;

  localparam int N = 10;

  logic         clk = 1'b0;
  logic         p_rst, s_rst, ref_clk, msk_sck, msk_din, cfg_we, pm_strap;
  logic [N-1:0] cfg_wdata, cfg_rdata, sclk_o;
  logic [1:0]   pwr_state;

  always #2.5 clk = ~clk;

  sclk_gate_ctrl #(.N_OUT(N)) dut (
    .clk(clk), .p_rst(p_rst), .s_rst(s_rst), .ref_clk(ref_clk),
    .msk_sck(msk_sck), .msk_din(msk_din), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pwr_state(pwr_state), .pm_strap(pm_strap), .sclk_o(sclk_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected-state model driven by the stimulus
  logic [N-1:0] exp_dis = '0;
  bit           exp_force = 0;
  string        sb_tag = "R2";
  bit           sb_on = 0;
  logic [N-1:0] sb_q[$];

  function automatic logic [N-1:0] expect_vec(input logic r);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = exp_force ? 1'b0 : (exp_dis[i] ? 1'b1 : r);
    return v;
  endfunction

  // driver: free-running reference, pushes the level it will produce
  int ref_cnt = 0;
  always @(negedge clk) begin
    ref_cnt = (ref_cnt + 1) % 8;
    ref_clk = (ref_cnt >= 4);
    if (sb_on) sb_q.push_back(expect_vec(ref_clk));
  end

  // monitor: pops expectations two samples behind
  always @(posedge clk) begin
    #1;
    if (sb_on && sb_q.size() >= 2) begin
      logic [N-1:0] e;
      e = sb_q.pop_front();
      chk(sclk_o === e, sb_tag, sclk_o, e);
    end
  end

  // R11: output changes only after a sampled reference change
  logic [N-1:0] prev_out = '0;
  logic r1 = 1'b0, r2 = 1'b0;
  int   quiet = 0;
  int   runt_cnt = 0;
  always @(posedge clk) begin
    #1;
    if (p_rst) quiet = 3;
    else if (quiet > 0) quiet--;
    else if (sclk_o !== prev_out && r1 == r2) runt_cnt++;
    prev_out = sclk_o;
    r2 = r1;
    r1 = ref_clk;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic window(input string tag, input int n);
    sb_tag = tag;
    cyc(24);
    sb_on = 1;
    cyc(n);
    sb_on = 0;
    sb_q.delete();
  endtask

  task automatic do_reset();
    p_rst = 1; s_rst = 1; msk_sck = 0; msk_din = 0; cfg_we = 0;
    exp_dis = '0;
    cyc(5);
    chk(cfg_rdata === '0, "R1 reg", cfg_rdata, '0);
    chk(sclk_o === '0, "R1 out", sclk_o, '0);
    p_rst = 0;
    cyc(2);
  endtask

  task automatic send_bit(input logic b);
    msk_din = b;
    cyc(4);
    msk_sck = 1;
    cyc(4);
    msk_sck = 0;
    cyc(2);
  endtask

  task automatic send_word(input logic [N-1:0] w);
    for (int i = N - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  localparam logic [N-1:0] PAT = 10'b1010011100;

  initial begin
    pm_strap = 0; pwr_state = 0; cfg_wdata = '0;
    p_rst = 1; s_rst = 1; msk_sck = 0; msk_din = 0; cfg_we = 0;

    // all-zero stream, then extra bits after the tenth
    do_reset();
    send_word('0);
    send_bit(1'b1);
    chk(cfg_rdata === '0, "R4 extra bit", cfg_rdata, '0);
    s_rst = 0;
    window("R6 zeros pass", 16);
    window("R2 pass", 16);

    // patterned stream, first bit lands in bit 9
    do_reset();
    send_word(PAT);
    chk(cfg_rdata === PAT, "R3 pattern", cfg_rdata, PAT);
    send_bit(1'b0);
    send_bit(1'b1);
    chk(cfg_rdata === PAT, "R4 after ten", cfg_rdata, PAT);
    s_rst = 0;
    exp_dis = PAT;
    window("R7 serial mask", 16);

    // all-ones stream
    do_reset();
    send_word('1);
    s_rst = 0;
    exp_dis = '1;
    window("R6 ones high", 16);

    // early close plus writes blocked before/during window
    p_rst = 1; s_rst = 1; msk_sck = 0; cfg_we = 0;
    cyc(5);
    p_rst = 0;
    cfg_we = 1; cfg_wdata = 10'h155;
    cyc(1);
    cfg_we = 0;
    send_bit(1'b1);
    send_bit(1'b0);
    cfg_we = 1; cfg_wdata = 10'h3FF;
    cyc(1);
    cfg_we = 0;
    cyc(2);
    chk(cfg_rdata === 10'b10, "R8 write ignored", cfg_rdata, 10'b10);
    send_bit(1'b1);
    send_bit(1'b1);
    s_rst = 0;
    cyc(3);
    send_bit(1'b1);
    send_bit(1'b0);
    chk(cfg_rdata === 10'b1011, "R5 early close", cfg_rdata, 10'b1011);

    // software write after the window
    cfg_we = 1; cfg_wdata = 10'h0F0;
    cyc(1);
    cfg_we = 0;
    chk(cfg_rdata === 10'h0F0, "R7 write", cfg_rdata, 10'h0F0);
    exp_dis = 10'h0F0;
    window("R7 sw mask", 16);

    // power states
    pm_strap = 1; pwr_state = 3; exp_force = 1;
    window("R9 d3 low", 16);
    pwr_state = 2;
    window("R9 d2 low", 16);
    pwr_state = 1; exp_force = 0;
    window("R10 d1", 16);
    pwr_state = 0;
    window("R10 d0", 16);
    pm_strap = 0; pwr_state = 3;
    window("R10 strap off", 16);
    pm_strap = 1; exp_force = 1;
    window("R9 strap on", 16);
    pm_strap = 0; pwr_state = 0; exp_force = 0;
    cfg_we = 1; cfg_wdata = 10'h000;
    cyc(1);
    cfg_we = 0;
    exp_dis = '0;
    window("R2 pass after", 16);

    chk(runt_cnt == 0, "R11 no runt", N'(runt_cnt), '0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule